// File: doc/BRIEF.md
# Multi-Modulation Deinterleaver Address Generator

This block produces the read-side address sequence that undoes the two-step block interleaving applied to one coded block. A block of N coded bits is viewed as a grid of d rows (d is 16 or 12) and C columns, where C is programmed per block and N = d·C. Bits arrive in row-major order. For each arriving bit the block issues the memory address that the bit belongs to, one address per clock cycle. The address is the column-major position of the bit after an intra-group rotation. The rotation depends on the modulation, through the group size s of 1, 2 or 3 (half the coded bits per subcarrier).

The arithmetic uses only counters, a small modulo-s add, one multiplier and one adder. It has no division and no address table, and all three modulations and every programmed depth share the same datapath. A one-cycle start pulse latches the configuration and launches a block. The block then runs by itself and flags its final address.

Top module: `dintl_addr_gen`

## Requirements
- R1: After reset, addrValid and addrLast are low, and they stay low until a block is started.
- R2: With modSel 0 (two coded bits per subcarrier) or modSel 3 (handled the same way), the bit with received index j = r·C + c, where r is the row and c the column (0 ≤ c < C), gets address c·d + r.
- R3: With modSel 1 (s = 2) or modSel 2 (s = 3), the column is first replaced by c − (c mod s) + ((c mod s) + r) mod s, and the address is then that column times d plus r. This equals the reference formula k = d·m − (N−1)·floor(d·m/N), with m = s·floor(j/s) + (j + floor(d·j/N)) mod s.
- R4: depthSel 0 selects d = 16 rows and depthSel 1 selects d = 12 rows. numCols gives C, which must be a non-zero multiple of s.
- R5: A block issues exactly N = d·C addresses on consecutive cycles, in increasing j. addrLast is high together with addrValid only on index N−1, and addrValid is low on the cycle after addrLast.
- R6: A start pulse while a block is running is ignored. The modSel, depthSel and numCols values are sampled only when a block is accepted, and changes to them during a block have no effect.
- R7: The addresses of each block cover 0 to N−1, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that starts a block when idle |
| modSel | input | 2 | Modulation: 0 two-bit, 1 four-bit, 2 six-bit, 3 as 0 |
| depthSel | input | 1 | Row count: 0 gives 16, 1 gives 12 |
| numCols | input | COL_W | Column count C of the block |
| addr | output | ADDR_W | Deinterleaver address |
| addrValid | output | 1 | addr holds a new address this cycle |
| addrLast | output | 1 | addr is the final address of the block |

## Verification
The bench drives every modulation code, including the alias code 3, with both row counts and with column counts that range from the smallest legal value (C = s) up to 24. Running the two-bit cases separately from the rotating cases shows whether a fault lies in the row/column mapping or in the modulo-s rotation. Running 16 rows against 12 rows exposes multiplier or row-wrap errors. Every address is compared with the reference floor formula and checked for uniqueness within its block. One block receives a second start pulse and new configuration inputs partway through, which shows whether the latched configuration is protected. Blocks are started back to back, which tests the end-of-block handoff.

// File: rtl/dintl_pkg.sv
package dintl_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dintlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // latch configuration, clear counters
    logic step;   // issue current index and advance
  } dintlCtrl_t;

  // group size s from modulation select; code 3 aliases code 0
  function automatic logic [1:0] groupSize(input logic [1:0] sel);
    case (sel)
      2'd1:    groupSize = 2'd2;
      2'd2:    groupSize = 2'd3;
      default: groupSize = 2'd1;
    endcase
  endfunction

  // row count d from depth select
  function automatic logic [4:0] rowCount(input logic sel);
    rowCount = sel ? 5'd12 : 5'd16;
  endfunction

endpackage

// File: rtl/dintl_ctrl.sv
module dintl_ctrl
  import dintl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       finalIdx,
  output dintlCtrl_t ctl
);

  dintlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    ctl.load  = 1'b0;
    ctl.step  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.load  = 1'b1;
          stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        ctl.step = 1'b1;
        if (finalIdx) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  // R6: a start pulse in RUN must not leave RUN
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !finalIdx) |=> (state == ST_RUN));

endmodule

// File: rtl/dintl_datapath.sv
module dintl_datapath
  import dintl_pkg::*;
#(
  parameter int MAX_COLS = 96,
  localparam int COL_W  = $clog2(MAX_COLS + 1),
  localparam int ADDR_W = $clog2(16 * MAX_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dintlCtrl_t        ctl,
  input  logic [1:0]        modSel,
  input  logic              depthSel,
  input  logic [COL_W-1:0]  numCols,
  output logic              finalIdx,
  output logic [ADDR_W-1:0] addr,
  output logic              addrValid,
  output logic              addrLast
);

  // latched configuration
  logic [1:0]       cfgS;
  logic [4:0]       cfgD;
  logic [COL_W-1:0] cfgCols;

  // index counters: j = rowCnt*C + colCnt
  logic [COL_W-1:0] colCnt;
  logic [3:0]       rowCnt;
  logic [1:0]       phase;     // colCnt mod s
  logic [1:0]       rot;       // rowCnt mod s

  logic colEnd, rowEnd, phaseWrap, rotWrap;
  logic [2:0]       rotSum;
  logic [1:0]       rotMod;
  logic [COL_W-1:0] mappedCol;
  logic [ADDR_W-1:0] product, addrNext;

  assign colEnd    = (colCnt == cfgCols - COL_W'(1));
  assign rowEnd    = ({1'b0, rowCnt} == cfgD - 5'd1);
  assign phaseWrap = (phase == cfgS - 2'd1);
  assign rotWrap   = (rot == cfgS - 2'd1);
  assign finalIdx  = ctl.step && colEnd && rowEnd;

  // intra-group rotation, no division: operands below s, one conditional subtract
  assign rotSum    = {1'b0, phase} + {1'b0, rot};
  assign rotMod    = (rotSum >= {1'b0, cfgS}) ? 2'(rotSum - {1'b0, cfgS}) : rotSum[1:0];
  assign mappedCol = colCnt - COL_W'(phase) + COL_W'(rotMod);

  // shared multiply/add
  assign product  = ADDR_W'(mappedCol) * ADDR_W'(cfgD);
  assign addrNext = product + ADDR_W'(rowCnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgS    <= 2'd1;
      cfgD    <= 5'd16;
      cfgCols <= COL_W'(1);
      colCnt  <= '0;
      rowCnt  <= '0;
      phase   <= '0;
      rot     <= '0;
    end else if (ctl.load) begin
      cfgS    <= groupSize(modSel);
      cfgD    <= rowCount(depthSel);
      cfgCols <= numCols;
      colCnt  <= '0;
      rowCnt  <= '0;
      phase   <= '0;
      rot     <= '0;
    end else if (ctl.step) begin
      if (colEnd) begin
        colCnt <= '0;
        phase  <= '0;
        rowCnt <= rowCnt + 4'd1;
        rot    <= rotWrap ? 2'd0 : rot + 2'd1;
      end else begin
        colCnt <= colCnt + COL_W'(1);
        phase  <= phaseWrap ? 2'd0 : phase + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr      <= '0;
      addrValid <= 1'b0;
      addrLast  <= 1'b0;
    end else begin
      addrValid <= ctl.step;
      addrLast  <= finalIdx;
      if (ctl.step) addr <= addrNext;
    end
  end

  // R3: rotation state stays inside one group
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.step |-> (phase < cfgS && rot < cfgS));

  // R7: issued address lies inside the block
  p_addr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid |-> ({1'b0, addr} < (ADDR_W+1)'(cfgD) * (ADDR_W+1)'(cfgCols)));

  // R6: configuration frozen across consecutive running cycles
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && !ctl.load) |=> (ctl.step ? $stable({cfgS, cfgD, cfgCols}) : 1'b1));

endmodule

// File: rtl/dintl_addr_gen.sv
module dintl_addr_gen
  import dintl_pkg::*;
#(
  parameter int MAX_COLS = 96,
  localparam int COL_W  = $clog2(MAX_COLS + 1),
  localparam int ADDR_W = $clog2(16 * MAX_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        modSel,
  input  logic              depthSel,
  input  logic [COL_W-1:0]  numCols,
  output logic [ADDR_W-1:0] addr,
  output logic              addrValid,
  output logic              addrLast
);

  dintlCtrl_t ctl;
  logic       finalIdx;

  dintl_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .finalIdx (finalIdx),
    .ctl      (ctl)
  );

  dintl_datapath #(.MAX_COLS(MAX_COLS)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .modSel    (modSel),
    .depthSel  (depthSel),
    .numCols   (numCols),
    .finalIdx  (finalIdx),
    .addr      (addr),
    .addrValid (addrValid),
    .addrLast  (addrLast)
  );

  // R5: last flag only accompanies a valid address
  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addrLast |-> addrValid);

  // R5: the cycle after the final address carries no address
  p_gap_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addrLast |=> !addrValid);

endmodule

// File: tb/dintl_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dintl_addr_gen_tb_top;

  localparam int MAX_COLS = 96;
  localparam int COL_W  = $clog2(MAX_COLS + 1);
  localparam int ADDR_W = $clog2(16 * MAX_COLS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] modSel = 2'd0;
  logic depthSel = 1'b0;
  logic [COL_W-1:0] numCols = '0;
  logic [ADDR_W-1:0] addr;
  logic addrValid, addrLast;

  always #2.5 clk = ~clk;

  dintl_addr_gen #(.MAX_COLS(MAX_COLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .modSel(modSel),
    .depthSel(depthSel), .numCols(numCols),
    .addr(addr), .addrValid(addrValid), .addrLast(addrLast)
  );

  typedef struct {
    int    a;
    bit    last;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  int curN    = 0;
  int seenCnt = 0;
  bit seen [0:2047];
  bit prevLast = 0;
  bit done = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // reference floor formula, independent of the counter structure
  function automatic int refAddr(input int j, input int s, input int d, input int n);
    int m;
    m = s * (j / s) + ((j + (d * j) / n) % s);
    return d * m - (n - 1) * ((d * m) / n);
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prevLast)
        check(!addrValid, "R5 valid after last", int'(addrValid), 0);
      if (addrValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 extra address", int'(addr), -1);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(int'(addr) == e.a && addrLast == e.last,
                $sformatf("%s addr/last (last act=%0d exp=%0d)", e.tag, addrLast, e.last),
                int'(addr), e.a);
          if (int'(addr) < 2048) begin
            if (seen[int'(addr)])
              check(1'b0, "R7 duplicate address", int'(addr), -1);
            seen[int'(addr)] = 1'b1;
            seenCnt++;
          end
        end
        if (addrLast) begin
          check(seenCnt == curN, "R7 distinct address count", seenCnt, curN);
          seenCnt = 0;
          for (int i = 0; i < 2048; i++) seen[i] = 1'b0;
        end
      end
      prevLast = addrLast;
    end
  end

  task automatic runBlock(input int mod, input int dsel, input int cols,
                          input bit disturb, input string tag);
    int d, s, n;
    d = dsel ? 12 : 16;
    s = (mod == 1) ? 2 : (mod == 2) ? 3 : 1;
    n = d * cols;
    curN = n;
    for (int j = 0; j < n; j++) begin
      expItem_t e;
      e.a = refAddr(j, s, d, n);
      e.last = (j == n - 1);
      e.tag = tag;
      expQ.push_back(e);
    end
    @(posedge clk); #1;
    start = 1'b1; modSel = 2'(mod); depthSel = 1'(dsel); numCols = COL_W'(cols);
    @(posedge clk); #1;
    start = 1'b0;
    if (disturb) begin
      repeat (5) @(posedge clk);
      #1;
      start = 1'b1; modSel = 2'd2; depthSel = ~depthSel; numCols = COL_W'(6);
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (expQ.size() != 0) @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) seen[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk) begin
      check(!addrValid && !addrLast, "R1 outputs idle after reset",
            int'({addrValid, addrLast}), 0);
    end
    runBlock(0, 0, 12, 0, "R2 two-bit d16");
    runBlock(1, 0, 12, 0, "R3 four-bit d16");
    runBlock(2, 0, 12, 0, "R3 six-bit d16");
    runBlock(0, 1, 8,  0, "R4 two-bit d12");
    runBlock(1, 1, 16, 0, "R4 four-bit d12");
    runBlock(2, 1, 24, 0, "R4 six-bit d12");
    runBlock(3, 0, 4,  0, "R2 alias code3");
    runBlock(2, 0, 3,  0, "R3 six-bit minimum C");
    runBlock(1, 0, 2,  0, "R3 four-bit minimum C");
    runBlock(1, 0, 10, 1, "R6 disturbed block");
    runBlock(2, 1, 6,  0, "R5 back-to-back");
    repeat (4) @(negedge clk) begin
      check(!addrValid, "R5 idle after final block", int'(addrValid), 0);
    end
    check(expQ.size() == 0, "R5 pending addresses", expQ.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired (R5 block never completed) actual=%0d expected=%0d",
               expQ.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule